// File: doc/BRIEF.md
# Dual 16-bit Reference Timer Pair

Two 16-bit up-counters sit behind a small synchronous register port and share one control byte. Each counter is driven by its own three-stage tick generator: an optional divide-by-16 stage, an 8-bit primary divider and an 8-bit secondary divider. On every tick the counter value is compared with a 16-bit reference. A match latches an event flag that software clears by writing 1. A match also raises the timer's interrupt line when interrupts are enabled in its mode register. After the match the counter either goes back to zero or keeps counting.

Software sets up a timer while it is held in reset. It then releases the timer through the shared control byte and can freeze it with a stop bit. It polls or acknowledges the event flag. Byte writes reach either half of a 16-bit register. Reads return the live counter and the current event state one cycle after the address is presented.

Register map (byte offsets; channel 1 is channel 0 plus 0x10): 0x00 control byte; 0x02 counter; 0x04 reference; 0x06 mode; 0x08 primary divider (8 bits); 0x0A event. Offsets 0x10, 0x0C, 0x0E, 0x1C and 0x1E read as zero.

Top module: `dual_ref_timer`

## Requirements
- R1: After a synchronous reset every register, `bus_rdata` and `irq` are zero, so both channels start held in reset.
- R2: When mode bits [2:1] = 1 (internal clock) and both dividers are 0, a running channel's counter increments on every clock cycle. The value of the register at `bus_addr` appears on `bus_rdata` one cycle after the address.
- R3: Control bit 0 (channel 0) and control bit 4 (channel 1) release the channel when set. While the bit is clear, that channel's counter, divider state and event flag are forced to zero.
- R4: Control bit 1 (channel 0) and control bit 5 (channel 1) stop the channel when set. Its counter and divider state hold their values until the bit is cleared.
- R5: The tick period is (mode[2:1]==2 ? 16 : 1) × (divider register + 1) × (mode[15:8] + 1) clock cycles, counted from release.
- R6: With mode bit 3 set, a tick on which the counter equals the reference loads zero, so the count repeats every reference+1 ticks.
- R7: A match sets event bit 1. Writing a 1 to event bit 1 clears it. Writing 0 there, or writing only the upper byte, has no effect.
- R8: `irq[c]` is high when channel c's event bit 1 is set and its mode bit 4 is set. It follows that condition one cycle later.
- R9: Software can write the counter directly, and that write takes precedence over a tick in the same cycle.
- R10: With mode bit 3 clear, a match still sets the event and the counter carries on, wrapping from 0xFFFF to 0x0000.
- R11: Clock source codes 0 (cascade) and 3 never produce ticks, so the counter does not move.
- R12: When `bus_half`=1 the write is 16-bit and `bus_addr[0]` is ignored. When `bus_half`=0 the write takes one byte from `bus_wdata[7:0]` and puts it in bits [7:0] for an even address or bits [15:8] for an odd one. The control byte exists only at offset 0x00, so a byte write to 0x01 changes nothing.
- R13: When an event-clear write lands on the same cycle as a new match, the event stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_half | input | 1 | 1: 16-bit access, 0: byte access |
| bus_addr | input | 5 | Byte address for read and write |
| bus_wdata | input | 16 | Write data (byte writes use bits [7:0]) |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 2 | Per-channel interrupt request |

## Verification
A corrupted divider or counter register shows up as a wrong frozen count after a stop. Every count check is placed an exact number of edges after release, so an off-by-one in the tick or restart logic changes the value that is read. A wrong event or enable state shows on `irq` two cycles after the fault and on the event register one read later. The clear-versus-match race is lined up to the exact edge, so giving the clear priority leaves the event flag at zero.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int BUS_W = 16;
  localparam int ADR_W = 5;

  // register index inside a channel window (byte address [3:1])
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_CNT  = 3'd1;
  localparam logic [2:0] IDX_REF  = 3'd2;
  localparam logic [2:0] IDX_MODE = 3'd3;
  localparam logic [2:0] IDX_PRE  = 3'd4;
  localparam logic [2:0] IDX_EVT  = 3'd5;

  // mode register fields
  localparam int MODE_SRC_LO = 1;
  localparam int MODE_RESTART = 3;
  localparam int MODE_IRQ_EN = 4;
  localparam int MODE_SEC_LO = 8;
  localparam int EVT_REF_BIT = 1;

  typedef enum logic [1:0] {
    SRC_CASCADE = 2'd0,
    SRC_INTERNAL = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_RESERVED = 2'd3
  } clk_src_e;

  // control-byte bit positions for channel c of the pair
  function automatic int stop_bit(input int c);
    return 1 + 4 * c;
  endfunction

  function automatic int rel_bit(input int c);
    return 4 * c;
  endfunction

  // merge a 16-bit or single-byte write into an existing value
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old,
                                                  input logic [BUS_W-1:0] wd,
                                                  input logic half,
                                                  input logic hi);
    if (half) return wd;
    if (hi) return {wd[7:0], old[7:0]};
    return {old[15:8], wd[7:0]};
  endfunction
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int PW = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          slow,
  input  logic [PW-1:0] pri,
  input  logic [PW-1:0] sec,
  output logic          tick
);
  localparam int SW = $clog2(SLOW_DIV);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [SW-1:0] s_q;
  logic [PW-1:0] p_q, q_q;
  logic s_end, p_last, q_last, p_end;

  assign s_end  = slow ? (s_q == SLOW_LAST) : 1'b1;
  assign p_last = (p_q >= pri);
  assign q_last = (q_q >= sec);
  assign p_end  = s_end && p_last;
  assign tick   = en && p_end && q_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      s_q <= '0;
      p_q <= '0;
      q_q <= '0;
    end else if (en) begin
      if (slow) s_q <= s_end ? '0 : s_q + 1'b1;
      if (s_end) p_q <= p_last ? '0 : p_q + 1'b1;
      if (p_end) q_q <= q_last ? '0 : q_q + 1'b1;
    end
  end

  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> (p_q == $past(p_q) && q_q == $past(q_q))); // R4

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (p_q == '0 && q_q == '0 && s_q == '0)); // R3
endmodule

// File: rtl/drt_busdec.sv
module drt_busdec import drt_pkg::*; #(
  parameter int NCH = 2
) (
  input  logic             we,
  input  logic             half,
  input  logic [ADR_W-1:0] addr,
  output logic             ctrl_we,
  output logic [NCH-1:0]   ch_we,
  output logic [2:0]       idx,
  output logic             hi
);
  logic ch_sel;

  assign idx    = addr[3:1];
  assign ch_sel = addr[4];
  assign hi     = addr[0] && !half;
  assign ctrl_we = we && !ch_sel && (idx == IDX_CTRL) && !hi;

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign ch_we[c] = we && (ch_sel == c[0]) && (idx != IDX_CTRL);
  end
endmodule

// File: rtl/drt_channel.sv
module drt_channel import drt_pkg::*; #(
  parameter int PW = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rel,
  input  logic             halt,
  input  logic             we,
  input  logic [2:0]       idx,
  input  logic             half,
  input  logic             hi,
  input  logic [BUS_W-1:0] wd,
  output logic [BUS_W-1:0] cnt_o,
  output logic [BUS_W-1:0] ref_o,
  output logic [BUS_W-1:0] mode_o,
  output logic [BUS_W-1:0] pre_o,
  output logic [BUS_W-1:0] evt_o,
  output logic             irq_o
);
  logic [BUS_W-1:0] cnt_q, ref_q, mode_q;
  logic [PW-1:0]    pre_q;
  logic             evt_q, irq_q;
  logic             wr_cnt, wr_ref, wr_mode, wr_pre, wr_evt;
  logic             evt_clr, running, tick, hit, restart;
  logic [BUS_W-1:0] pre_wide, pre_new;
  clk_src_e         src;

  assign wr_cnt  = we && (idx == IDX_CNT);
  assign wr_ref  = we && (idx == IDX_REF);
  assign wr_mode = we && (idx == IDX_MODE);
  assign wr_pre  = we && (idx == IDX_PRE);
  assign wr_evt  = we && (idx == IDX_EVT);
  assign evt_clr = wr_evt && !hi && wd[EVT_REF_BIT];

  assign src     = clk_src_e'(mode_q[MODE_SRC_LO +: 2]);
  assign restart = mode_q[MODE_RESTART];
  assign running = rel && !halt && (src == SRC_INTERNAL || src == SRC_SLOW);
  assign hit     = tick && (cnt_q == ref_q);

  assign pre_wide = {{(BUS_W-PW){1'b0}}, pre_q};
  assign pre_new  = lane_merge(pre_wide, wd, half, hi);

  drt_prescaler #(.PW(PW), .SLOW_DIV(SLOW_DIV)) i_pre (
    .clk (clk),
    .rst (rst),
    .clr (!rel),
    .en  (running),
    .slow(src == SRC_SLOW),
    .pri (pre_q),
    .sec (mode_q[MODE_SEC_LO +: PW]),
    .tick(tick)
  );

  // configuration registers are not touched by the channel reset bit
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      mode_q <= '0;
      pre_q  <= '0;
    end else begin
      if (wr_ref) ref_q <= lane_merge(ref_q, wd, half, hi);
      if (wr_mode) mode_q <= lane_merge(mode_q, wd, half, hi);
      if (wr_pre) pre_q <= pre_new[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rel) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      if (wr_cnt) cnt_q <= lane_merge(cnt_q, wd, half, hi);
      else if (tick) cnt_q <= (hit && restart) ? '0 : cnt_q + 1'b1;
      evt_q <= (evt_q && !evt_clr) || hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= evt_q && mode_q[MODE_IRQ_EN];
  end

  assign cnt_o  = cnt_q;
  assign ref_o  = ref_q;
  assign mode_o = mode_q;
  assign pre_o  = pre_wide;
  assign evt_o  = {{(BUS_W-EVT_REF_BIT-1){1'b0}}, evt_q, {EVT_REF_BIT{1'b0}}};
  assign irq_o  = irq_q;

  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !rel |=> (cnt_q == '0 && !evt_q)); // R3

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rel && halt && !wr_cnt) |=> (cnt_q == $past(cnt_q))); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rel && hit && restart && !wr_cnt) |=> (cnt_q == '0)); // R6

  AST_MATCH_SETS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (rel && hit) |=> evt_q); // R13

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (rel && tick && !restart && !wr_cnt && cnt_q == '1) |=> (cnt_q == '0)); // R10

  AST_NO_TICK_IDLE_SRC: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_CASCADE || src == SRC_RESERVED) |-> !tick); // R11
endmodule

// File: rtl/dual_ref_timer.sv
module dual_ref_timer import drt_pkg::*; #(
  parameter int PW = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_half,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [1:0]       irq
);
  localparam int NCH = 2;

  logic [7:0]       ctrl_q;
  logic             ctrl_we, hi;
  logic [NCH-1:0]   ch_we;
  logic [2:0]       idx;
  logic [BUS_W-1:0] cnt_v [NCH];
  logic [BUS_W-1:0] ref_v [NCH];
  logic [BUS_W-1:0] mode_v [NCH];
  logic [BUS_W-1:0] pre_v [NCH];
  logic [BUS_W-1:0] evt_v [NCH];
  logic [BUS_W-1:0] rd_next, rdata_q;

  drt_busdec #(.NCH(NCH)) i_dec (
    .we     (bus_we),
    .half   (bus_half),
    .addr   (bus_addr),
    .ctrl_we(ctrl_we),
    .ch_we  (ch_we),
    .idx    (idx),
    .hi     (hi)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata[7:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    drt_channel #(.PW(PW), .SLOW_DIV(SLOW_DIV)) i_ch (
      .clk   (clk),
      .rst   (rst),
      .rel   (ctrl_q[rel_bit(c)]),
      .halt  (ctrl_q[stop_bit(c)]),
      .we    (ch_we[c]),
      .idx   (idx),
      .half  (bus_half),
      .hi    (hi),
      .wd    (bus_wdata),
      .cnt_o (cnt_v[c]),
      .ref_o (ref_v[c]),
      .mode_o(mode_v[c]),
      .pre_o (pre_v[c]),
      .evt_o (evt_v[c]),
      .irq_o (irq[c])
    );
  end

  always_comb begin
    rd_next = '0;
    case (idx)
      IDX_CTRL: rd_next = bus_addr[4] ? '0 : {8'h00, ctrl_q};
      IDX_CNT:  rd_next = cnt_v[bus_addr[4]];
      IDX_REF:  rd_next = ref_v[bus_addr[4]];
      IDX_MODE: rd_next = mode_v[bus_addr[4]];
      IDX_PRE:  rd_next = pre_v[bus_addr[4]];
      IDX_EVT:  rd_next = evt_v[bus_addr[4]];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  AST_CTRL_ODD_BYTE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_half && bus_addr == 5'h01) |=> (ctrl_q == $past(ctrl_q))); // R12

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[4:1] == 4'h0 && (bus_half || !bus_addr[0]))
      |=> (ctrl_q == $past(bus_wdata[7:0]))); // R12
endmodule

// File: tb/test_dual_ref_timer.sv
module test_dual_ref_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_half = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    int          ch;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  dual_ref_timer i_dual_ref_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = sb.pop_front();
      got = it.is_irq ? {15'd0, irq[it.ch]} : bus_rdata;
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_half = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr8(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_half = 1'b0; bus_addr = a; bus_wdata = {8'hA5, d};
    @(negedge clk);
    bus_we = 1'b0; bus_half = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1;
    it.is_irq = 1'b0; it.ch = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_irq(input int ch, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    @(posedge clk);
    #1;
    it.is_irq = 1'b1; it.ch = ch; it.exp = {15'd0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  localparam logic [4:0] CTRL = 5'h00;
  localparam logic [4:0] CNT0 = 5'h02, REF0 = 5'h04, MODE0 = 5'h06, PRE0 = 5'h08, EVT0 = 5'h0A;
  localparam logic [4:0] CNT1 = 5'h12, MODE1 = 5'h16, PRE1 = 5'h18, EVT1 = 5'h1A;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(CTRL, 16'h0000, "R1 control after reset");
    rd(CNT0, 16'h0000, "R1 counter0 after reset");
    rd(MODE1, 16'h0000, "R1 mode1 after reset");
    rd(EVT0, 16'h0000, "R1 event0 after reset");
    chk_irq(0, 1'b0, "R1 irq0 after reset");

    // R2 count at divide-by-one, 10 edges between release and stop
    wr16(MODE0, 16'h0002);
    wr16(REF0, 16'hFFFF);
    wr16(CTRL, 16'h0001);
    idle(8);
    wr16(CTRL, 16'h0003);
    rd(CNT0, 16'd10, "R2 counter0 after 10 cycles");
    idle(20);
    rd(CNT0, 16'd10, "R4 counter0 held while stopped");

    // R5 slow source, primary 2, secondary 1: period 96, 338 edges
    wr16(MODE1, 16'h0104);
    wr16(PRE1, 16'h0002);
    wr16(CTRL, 16'h0013);
    idle(336);
    wr16(CTRL, 16'h0033);
    rd(CNT1, 16'd3, "R5 counter1 after 338 cycles at /96");
    rd(EVT1, 16'h0002, "R10 match on zero in free run sets event1");
    chk_irq(1, 1'b0, "R8 irq1 low with enable clear");

    // R3 hold channel 0 in reset
    wr16(CTRL, 16'h0030);
    rd(CNT0, 16'h0000, "R3 counter0 cleared in reset");
    rd(CNT1, 16'd3, "R4 counter1 unaffected while stopped");

    // R6/R7/R8 restart with reference 4, 13 edges
    wr16(MODE0, 16'h001A);
    wr16(REF0, 16'h0004);
    wr16(CTRL, 16'h0031);
    idle(11);
    wr16(CTRL, 16'h0033);
    rd(CNT0, 16'd3, "R6 counter0 restart period 5");
    rd(EVT0, 16'h0002, "R7 event0 set by match");
    chk_irq(0, 1'b1, "R8 irq0 raised");

    // R7 write-one-to-clear
    wr16(EVT0, 16'h0000);
    rd(EVT0, 16'h0002, "R7 zero write keeps event");
    wr8(5'h0B, 8'hFF);
    rd(EVT0, 16'h0002, "R7 upper byte write keeps event");
    wr16(EVT0, 16'hFFFF);
    rd(EVT0, 16'h0000, "R7 one write clears event");
    chk_irq(0, 1'b0, "R8 irq0 drops after clear");

    // R9/R10 direct load and wrap
    wr16(MODE0, 16'h0012);
    wr16(CNT0, 16'hFFFC);
    wr16(REF0, 16'hFFFE);
    rd(CNT0, 16'hFFFC, "R9 direct counter load");
    wr16(CTRL, 16'h0031);
    idle(3);
    wr16(CTRL, 16'h0033);
    rd(CNT0, 16'h0001, "R10 free run wraps through zero");
    rd(EVT0, 16'h0002, "R10 free run match sets event");
    chk_irq(0, 1'b1, "R8 irq0 on free-run match");

    // R8 interrupt disable
    wr16(MODE0, 16'h0002);
    chk_irq(0, 1'b0, "R8 irq0 low with enable cleared");
    rd(EVT0, 16'h0002, "R8 event kept when enable cleared");

    // R11 cascade and reserved sources do not count
    wr16(EVT0, 16'hFFFF);
    wr16(CNT0, 16'h0000);
    wr16(MODE0, 16'h0000);
    wr16(CTRL, 16'h0031);
    idle(5);
    wr16(CTRL, 16'h0033);
    rd(CNT0, 16'h0000, "R11 cascade source frozen");
    wr16(MODE0, 16'h0006);
    wr16(CTRL, 16'h0031);
    idle(5);
    wr16(CTRL, 16'h0033);
    rd(CNT0, 16'h0000, "R11 reserved source frozen");

    // R12 byte lanes
    wr8(5'h05, 8'h12);
    rd(REF0, 16'h12FE, "R12 odd byte writes upper half");
    wr8(5'h04, 8'h34);
    rd(REF0, 16'h1234, "R12 even byte writes lower half");
    wr8(5'h01, 8'hFF);
    rd(CTRL, 16'h0033, "R12 odd byte at control ignored");
    rd(5'h10, 16'h0000, "R12 channel1 window offset 0 reads zero");

    // R13 clear on same edge as match
    wr16(CTRL, 16'h0030);
    wr16(MODE0, 16'h000A);
    wr16(REF0, 16'h0004);
    wr16(CTRL, 16'h0031);
    idle(3);
    wr16(EVT0, 16'hFFFF);
    wr16(CTRL, 16'h0033);
    rd(EVT0, 16'h0002, "R13 new match beats clear");
    rd(CNT0, 16'd2, "R13 counter0 after 7 cycles");

    idle(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule